// File: doc/BRIEF.md
# AUX Channel Request Sequencer

This block runs one request on a DisplayPort AUX channel from start to finish. A request is a native register write, a native register read or a one-byte I2C-over-AUX transfer. The block packs it into a message with a four-byte header and streams the message to a downstream transaction engine over a byte handshake. It then takes the engine's reply stream and reads the reply in layers. The engine status comes first. Next comes the native reply code. For I2C requests, the I2C reply code is read last.

A deferred reply makes the block wait a programmable number of cycles and send the same message again. There are at most four attempts in total. When the request ends, the block gives a one-cycle `done` pulse. This pulse comes with an error code and, for reads, the received bytes cut down to the caller's buffer size. While the block is `busy`, new requests are ignored.

Top module: `aux_req_seq`

## Requirements
- R1: Header byte 0 is address bits [7:0] and byte 1 is address bits [15:8]. The upper nibble of byte 2 is the command: 8 for a native write, 9 for a native read, 0 for an I2C write, 1 for an I2C read. The lower nibble of byte 2 is 0.
- R2: For an I2C request with `req_mot`=1 (no stop), bit 6 of header byte 2 is set. For an I2C request with `req_mot`=0, and for every native request, bit 6 is clear.
- R3: The upper nibble of header byte 3 is the total message length in bytes: length+4 for a native write, 4 for a native read, 5 for an I2C write and 4 for an I2C read. The lower nibble is length-1 for native requests and 0 for I2C requests.
- R4: Header bytes 0 to 3 are sent first. A native write then sends payload bytes 0..length-1, and an I2C write sends payload byte 0; payload byte i sits at `req_wdata[8i+7:8i]`. `tx_last` marks the final byte. While `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values.
- R5: The reply stream starts with a status byte. If the status is 1, 2 or 3, the request ends with `err_code` 1, 2 or 3 (timeout, flags, engine error). Any other nonzero status ends it with code 7. None of these are retried.
- R6: When the status is 0, the next byte is a reply code. Bits [5:4] of that byte are the native reply: 0 = ACK, 1 = NACK (`err_code` 4), 2 = DEFER, 3 = invalid (`err_code` 7). A reply that ends with no code byte gives `err_code` 7.
- R7: Bits [7:6] are decoded only for I2C requests that received a native ACK: 0 = ACK, 1 = NACK (`err_code` 5), 2 = DEFER, 3 = invalid (`err_code` 7). For native requests, these bits are ignored.
- R8: After a DEFER, `tx_valid` stays low for exactly `req_defer_wait`+1 cycles after the edge that takes the last reply byte. The identical message is then sent again.
- R9: A request makes at most 4 attempts. If the fourth attempt is deferred, the request ends with `err_code` 6 and no fifth message is sent.
- R10: On success, `rd_count` is the smaller of the number of payload bytes received and the buffer size. The buffer size is `min(req_rbuf_size, MAX_BYTES)` for native reads, `min(req_rbuf_size, 1)` for I2C reads and 0 for writes. The bytes appear at `rd_data[8i+7:8i]`. On any error, `rd_count` is 0.
- R11: `busy` rises the cycle after a request is accepted. `done` is a one-cycle pulse, given in the same cycle that `busy` falls, with `err`=1 exactly when `err_code` is nonzero. While `busy` is high, `req_valid` has no effect and no extra message is sent.
- R12: After reset, `busy`, `done` and `tx_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a request (taken when idle) |
| req_kind | input | 2 | 0 native write, 1 native read, 2 I2C write, 3 I2C read |
| req_addr | input | 16 | Target address |
| req_len | input | LEN_W | Native payload length, 1..MAX_BYTES |
| req_mot | input | 1 | I2C transfer continues (no stop) |
| req_wdata | input | MAX_BYTES*8 | Write payload, byte i at bits [8i+7:8i] |
| req_rbuf_size | input | LEN_W | Caller read buffer size in bytes |
| req_defer_wait | input | WAIT_W | Idle cycles after a DEFER |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request failed (valid with done) |
| err_code | output | 3 | Failure reason (valid with done) |
| rd_data | output | MAX_BYTES*8 | Read bytes |
| rd_count | output | LEN_W | Number of valid read bytes |
| tx_valid | output | 1 | Message byte available |
| tx_ready | input | 1 | Engine accepts message byte |
| tx_data | output | 8 | Message byte |
| tx_last | output | 1 | Final byte of the message |
| rx_valid | input | 1 | Reply byte present |
| rx_data | input | 8 | Reply byte |
| rx_last | input | 1 | Final reply byte |

## Verification
Two things can happen in the same clock edge. The last reply byte can be a payload byte, which must be captured. The reply verdict is also decided on that same edge. So the reported count must already include that final byte, and it must still respect the clipping limit. The bench provokes this by sweeping the received payload length from 0 past `MAX_BYTES` against several buffer sizes. Every reply ends on a data byte whenever any are sent. The bench compares `rd_count` and every reported byte against the minimum it computes itself. Deferred replies also end on the same edge that starts the wait, and the bench times the gap to the resent header for several wait values.

// File: rtl/aux_seq_pkg.sv
package aux_seq_pkg;

  typedef enum logic [1:0] {
    K_NAT_WR = 2'd0,
    K_NAT_RD = 2'd1,
    K_I2C_WR = 2'd2,
    K_I2C_RD = 2'd3
  } req_kind_e;

  typedef enum logic [2:0] {
    E_NONE      = 3'd0,
    E_TIMEOUT   = 3'd1,
    E_FLAGS     = 3'd2,
    E_ENGINE    = 3'd3,
    E_NAT_NACK  = 3'd4,
    E_I2C_NACK  = 3'd5,
    E_RETRIES   = 3'd6,
    E_BAD_REPLY = 3'd7
  } err_e;

  typedef enum logic [1:0] {
    V_DONE  = 2'd0,
    V_RETRY = 2'd1,
    V_FAIL  = 2'd2
  } verdict_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_SEND  = 2'd1,
    S_REPLY = 2'd2,
    S_DEFER = 2'd3
  } seq_state_e;

  localparam logic [3:0] CMD_NAT_WR = 4'h8;
  localparam logic [3:0] CMD_NAT_RD = 4'h9;
  localparam logic [3:0] CMD_I2C_WR = 4'h0;
  localparam logic [3:0] CMD_I2C_RD = 4'h1;
  localparam logic [3:0] CMD_MOT    = 4'h4;

endpackage

// File: rtl/aux_hdr_build.sv
module aux_hdr_build
  import aux_seq_pkg::*;
#(
  parameter int MAX_BYTES = 8,
  parameter int LEN_W     = 4,
  parameter int MSG_W     = 4
) (
  input  logic [1:0]             kind,
  input  logic [15:0]            addr,
  input  logic [LEN_W-1:0]       len,
  input  logic                   mot,
  input  logic [MAX_BYTES*8-1:0] wdata,
  input  logic [MSG_W-1:0]       idx,
  output logic [7:0]             byte_o,
  output logic [MSG_W-1:0]       msg_len
);

  logic [7:0] total;
  logic [3:0] cmd;
  logic [3:0] lo;

  always_comb begin
    total = 8'd4;
    cmd   = CMD_NAT_RD;
    lo    = 4'(8'(len) - 8'd1);
    unique case (req_kind_e'(kind))
      K_NAT_WR: begin
        cmd   = CMD_NAT_WR;
        total = 8'(len) + 8'd4;
      end
      K_NAT_RD: begin
        cmd   = CMD_NAT_RD;
        total = 8'd4;
      end
      K_I2C_WR: begin
        cmd   = CMD_I2C_WR | (mot ? CMD_MOT : 4'h0);
        total = 8'd5;
        lo    = 4'h0;
      end
      K_I2C_RD: begin
        cmd   = CMD_I2C_RD | (mot ? CMD_MOT : 4'h0);
        total = 8'd4;
        lo    = 4'h0;
      end
      default: ;
    endcase
  end

  assign msg_len = MSG_W'(total);

  always_comb begin
    byte_o = 8'h00;
    case (int'(idx))
      0: byte_o = addr[7:0];
      1: byte_o = addr[15:8];
      2: byte_o = {cmd, 4'h0};
      3: byte_o = {total[3:0], lo};
      default: begin
        for (int i = 0; i < MAX_BYTES; i++) begin
          if (int'(idx) == i + 4) byte_o = wdata[8*i +: 8];
        end
      end
    endcase
  end

endmodule

// File: rtl/aux_reply_decode.sv
module aux_reply_decode
  import aux_seq_pkg::*;
(
  input  logic [7:0] status,
  input  logic [7:0] code,
  input  logic       have_code,
  input  logic       is_i2c,
  output verdict_e   verdict,
  output err_e       err
);

  always_comb begin
    verdict = V_FAIL;
    err     = E_BAD_REPLY;
    if (status != 8'd0) begin
      case (status)
        8'd1:    err = E_TIMEOUT;
        8'd2:    err = E_FLAGS;
        8'd3:    err = E_ENGINE;
        default: err = E_BAD_REPLY;
      endcase
    end else if (have_code) begin
      case (code[5:4])
        2'd0: begin
          if (!is_i2c) begin
            verdict = V_DONE;
            err     = E_NONE;
          end else begin
            case (code[7:6])
              2'd0: begin verdict = V_DONE;  err = E_NONE;     end
              2'd1: begin verdict = V_FAIL;  err = E_I2C_NACK; end
              2'd2: begin verdict = V_RETRY; err = E_NONE;     end
              default: begin verdict = V_FAIL; err = E_BAD_REPLY; end
            endcase
          end
        end
        2'd1:    err = E_NAT_NACK;
        2'd2: begin
          verdict = V_RETRY;
          err     = E_NONE;
        end
        default: err = E_BAD_REPLY;
      endcase
    end
  end

endmodule

// File: rtl/aux_rx_capture.sv
module aux_rx_capture #(
  parameter int MAX_BYTES = 8,
  parameter int LEN_W     = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clear,
  input  logic                   wr_en,
  input  logic [7:0]             wr_byte,
  input  logic [LEN_W-1:0]       limit,
  output logic [MAX_BYTES*8-1:0] buf_flat,
  output logic [LEN_W-1:0]       count,
  output logic [LEN_W-1:0]       count_nxt
);

  localparam int IDX_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;

  logic [7:0] mem [MAX_BYTES];
  logic       store;

  assign store = wr_en && !clear && (count < limit);

  always_ff @(posedge clk) begin
    if (store) mem[IDX_W'(count)] <= wr_byte;
  end

  always_comb begin
    if (clear)      count_nxt = '0;
    else if (store) count_nxt = count + LEN_W'(1);
    else            count_nxt = count;
  end

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= count_nxt;
  end

  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_flat
    assign buf_flat[8*g +: 8] = mem[g];
  end

  p_clip_r10: assert property (@(posedge clk) disable iff (rst)
    count <= limit);

endmodule

// File: rtl/aux_req_seq.sv
module aux_req_seq
  import aux_seq_pkg::*;
#(
  parameter int MAX_BYTES = 8,
  parameter int WAIT_W    = 8,
  parameter int MAX_TRIES = 4,
  localparam int LEN_W    = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic [1:0]             req_kind,
  input  logic [15:0]            req_addr,
  input  logic [LEN_W-1:0]       req_len,
  input  logic                   req_mot,
  input  logic [MAX_BYTES*8-1:0] req_wdata,
  input  logic [LEN_W-1:0]       req_rbuf_size,
  input  logic [WAIT_W-1:0]      req_defer_wait,
  output logic                   busy,
  output logic                   done,
  output logic                   err,
  output logic [2:0]             err_code,
  output logic [MAX_BYTES*8-1:0] rd_data,
  output logic [LEN_W-1:0]       rd_count,
  output logic                   tx_valid,
  input  logic                   tx_ready,
  output logic [7:0]             tx_data,
  output logic                   tx_last,
  input  logic                   rx_valid,
  input  logic [7:0]             rx_data,
  input  logic                   rx_last
);

  localparam int MSG_W = $clog2(MAX_BYTES + 5);
  localparam int TRY_W = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1;
  localparam logic [TRY_W-1:0] LAST_TRY = TRY_W'(MAX_TRIES - 1);

  seq_state_e             state_q;
  logic [1:0]             kind_q;
  logic [15:0]            addr_q;
  logic [LEN_W-1:0]       len_q;
  logic                   mot_q;
  logic [MAX_BYTES*8-1:0] wdata_q;
  logic [LEN_W-1:0]       lim_q;
  logic [WAIT_W-1:0]      wait_q;
  logic [WAIT_W-1:0]      wait_cnt;
  logic [TRY_W-1:0]       attempt_q;
  logic [MSG_W-1:0]       tx_idx;
  logic [MSG_W-1:0]       msg_len;
  logic [1:0]             rx_cnt;
  logic [7:0]             stat_q;
  logic [7:0]             code_q;
  logic                   busy_q, done_q, err_q, tx_valid_q;
  logic [2:0]             err_code_q;
  logic [LEN_W-1:0]       rd_count_q;

  logic [LEN_W-1:0] lim_nxt;
  logic             start, relaunch, cap_clear, cap_wr;
  logic [7:0]       stat_now, code_now;
  verdict_e         dec_verdict;
  err_e             dec_err;
  logic             fin, go_defer;
  err_e             fin_code;
  logic [LEN_W-1:0] cap_count, cap_count_nxt;

  // Message bytes are selected from the latched request, so a resend is identical.
  aux_hdr_build #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W), .MSG_W(MSG_W)) u_hdr (
    .kind(kind_q), .addr(addr_q), .len(len_q), .mot(mot_q), .wdata(wdata_q),
    .idx(tx_idx), .byte_o(tx_data), .msg_len(msg_len)
  );

  assign tx_last = tx_valid_q && (tx_idx == msg_len - MSG_W'(1));

  // The decision uses the byte arriving this cycle, not only stored bytes.
  assign stat_now = (rx_cnt == 2'd0) ? rx_data : stat_q;
  assign code_now = (rx_cnt == 2'd1) ? rx_data : code_q;

  aux_reply_decode u_dec (
    .status(stat_now), .code(code_now), .have_code(rx_cnt != 2'd0),
    .is_i2c(kind_q[1]), .verdict(dec_verdict), .err(dec_err)
  );

  assign start     = (state_q == S_IDLE) && req_valid;
  assign relaunch  = (state_q == S_DEFER) && (wait_cnt == '0);
  assign cap_clear = start || relaunch;
  assign cap_wr    = (state_q == S_REPLY) && rx_valid && (rx_cnt == 2'd2);

  aux_rx_capture #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) u_cap (
    .clk(clk), .rst(rst), .clear(cap_clear), .wr_en(cap_wr), .wr_byte(rx_data),
    .limit(lim_q), .buf_flat(rd_data), .count(cap_count), .count_nxt(cap_count_nxt)
  );

  always_comb begin
    case (req_kind_e'(req_kind))
      K_NAT_RD: lim_nxt = (req_rbuf_size > LEN_W'(MAX_BYTES)) ? LEN_W'(MAX_BYTES) : req_rbuf_size;
      K_I2C_RD: lim_nxt = (req_rbuf_size != '0) ? LEN_W'(1) : '0;
      default:  lim_nxt = '0;
    endcase
  end

  always_comb begin
    fin      = 1'b0;
    go_defer = 1'b0;
    fin_code = E_NONE;
    if (state_q == S_REPLY && rx_valid && rx_last) begin
      case (dec_verdict)
        V_DONE: fin = 1'b1;
        V_RETRY: begin
          if (attempt_q == LAST_TRY) begin
            fin      = 1'b1;
            fin_code = E_RETRIES;
          end else begin
            go_defer = 1'b1;
          end
        end
        default: begin
          fin      = 1'b1;
          fin_code = dec_err;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_IDLE;
      kind_q     <= '0;
      addr_q     <= '0;
      len_q      <= '0;
      mot_q      <= 1'b0;
      wdata_q    <= '0;
      lim_q      <= '0;
      wait_q     <= '0;
      wait_cnt   <= '0;
      attempt_q  <= '0;
      tx_idx     <= '0;
      rx_cnt     <= '0;
      stat_q     <= '0;
      code_q     <= '0;
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      err_code_q <= '0;
      rd_count_q <= '0;
      tx_valid_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (req_valid) begin
            kind_q     <= req_kind;
            addr_q     <= req_addr;
            len_q      <= req_len;
            mot_q      <= req_mot;
            wdata_q    <= req_wdata;
            lim_q      <= lim_nxt;
            wait_q     <= req_defer_wait;
            attempt_q  <= '0;
            tx_idx     <= '0;
            tx_valid_q <= 1'b1;
            busy_q     <= 1'b1;
            state_q    <= S_SEND;
          end
        end
        S_SEND: begin
          if (tx_ready) begin
            if (tx_idx == msg_len - MSG_W'(1)) begin
              tx_valid_q <= 1'b0;
              rx_cnt     <= '0;
              state_q    <= S_REPLY;
            end else begin
              tx_idx <= tx_idx + MSG_W'(1);
            end
          end
        end
        S_REPLY: begin
          if (rx_valid) begin
            if (rx_cnt != 2'd2) rx_cnt <= rx_cnt + 2'd1;
            if (rx_cnt == 2'd0) stat_q <= rx_data;
            if (rx_cnt == 2'd1) code_q <= rx_data;
          end
          if (fin) begin
            state_q    <= S_IDLE;
            busy_q     <= 1'b0;
            done_q     <= 1'b1;
            err_q      <= (fin_code != E_NONE);
            err_code_q <= fin_code;
            rd_count_q <= (fin_code == E_NONE) ? cap_count_nxt : '0;
          end else if (go_defer) begin
            attempt_q <= attempt_q + TRY_W'(1);
            wait_cnt  <= wait_q;
            state_q   <= S_DEFER;
          end
        end
        S_DEFER: begin
          if (wait_cnt == '0) begin
            tx_idx     <= '0;
            tx_valid_q <= 1'b1;
            state_q    <= S_SEND;
          end else begin
            wait_cnt <= wait_cnt - WAIT_W'(1);
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign err      = err_q;
  assign err_code = err_code_q;
  assign rd_count = rd_count_q;
  assign tx_valid = tx_valid_q;

  p_done_after_busy_r11: assert property (@(posedge clk) disable iff (rst)
    done_q |-> $past(busy_q));
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> !tx_valid_q);
  p_tx_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (tx_valid_q && !tx_ready) |=> (tx_valid_q && $stable(tx_data) && $stable(tx_last)));
  p_defer_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_DEFER) |-> !tx_valid_q);
  p_retry_cap_r9: assert property (@(posedge clk) disable iff (rst)
    (done_q && err_code_q == E_RETRIES) |-> (attempt_q == LAST_TRY));

endmodule

// File: tb/test_aux_req_seq.sv
module test_aux_req_seq;

  localparam int MAXB = 8;
  localparam int WW   = 8;
  localparam int LW   = $clog2(MAXB + 1);

  logic            clk = 1'b0;
  logic            rst;
  logic            req_valid = 1'b0;
  logic [1:0]      req_kind = '0;
  logic [15:0]     req_addr = '0;
  logic [LW-1:0]   req_len = '0;
  logic            req_mot = 1'b0;
  logic [MAXB*8-1:0] req_wdata = '0;
  logic [LW-1:0]   req_rbuf_size = '0;
  logic [WW-1:0]   req_defer_wait = '0;
  logic            busy, done, err;
  logic [2:0]      err_code;
  logic [MAXB*8-1:0] rd_data;
  logic [LW-1:0]   rd_count;
  logic            tx_valid, tx_last;
  logic            tx_ready = 1'b0;
  logic [7:0]      tx_data;
  logic            rx_valid = 1'b0;
  logic [7:0]      rx_data = '0;
  logic            rx_last = 1'b0;

  aux_req_seq #(.MAX_BYTES(MAXB), .WAIT_W(WW), .MAX_TRIES(4)) i_aux_req_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
    .req_len(req_len), .req_mot(req_mot), .req_wdata(req_wdata), .req_rbuf_size(req_rbuf_size),
    .req_defer_wait(req_defer_wait), .busy(busy), .done(done), .err(err), .err_code(err_code),
    .rd_data(rd_data), .rd_count(rd_count), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_last(tx_last), .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last)
  );

  always #2 clk = ~clk;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  finished = 0;
  int  r_stat[4];
  int  r_code[4];
  int  r_nd[4];
  bit  intrude = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  function automatic int dbyte(input int t, input int i);
    return (t * 37 + i * 11 + 5) & 255;
  endfunction

  function automatic int minv(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  // 0 = success, 1 = retry, 2 = fail (with e)
  function automatic int verdict(input int kind, input int st, input int cd, output int e);
    e = 0;
    if (st != 0) begin e = (st <= 3) ? st : 7; return 2; end
    if (cd < 0) begin e = 7; return 2; end
    case ((cd >> 4) & 3)
      1: begin e = 4; return 2; end
      2: return 1;
      3: begin e = 7; return 2; end
      default: begin
        if (kind < 2) return 0;
        case ((cd >> 6) & 3)
          0: return 0;
          1: begin e = 5; return 2; end
          2: return 1;
          default: begin e = 7; return 2; end
        endcase
      end
    endcase
  endfunction

  function automatic int exp_hdr(input int kind, input int addr, input int len, input int mot, input int idx);
    int total, cmd, lo;
    total = (kind == 0) ? len + 4 : (kind == 2) ? 5 : 4;
    cmd = (kind == 0) ? 8 : (kind == 1) ? 9 : (kind == 2) ? (mot ? 4 : 0) : (mot ? 5 : 1);
    lo = (kind < 2) ? len - 1 : 0;
    case (idx)
      0: return addr & 255;
      1: return (addr >> 8) & 255;
      2: return cmd << 4;
      3: return ((total & 15) << 4) | lo;
      default: return int'(req_wdata[8*(idx-4) +: 8]);
    endcase
  endfunction

  task automatic set_rep(input int t, input int st, input int cd, input int nd);
    r_stat[t] = st;
    r_code[t] = cd;
    r_nd[t] = nd;
  endtask

  task automatic run(input int kind, input int addr, input int len, input int mot,
                     input int rbuf, input int wt, input int bp);
    int exp_len, t, v, e, final_e, got, guard, nb, lows, lim, exp_cnt;
    bit hdr_ok, data_ok;
    exp_len = (kind == 0) ? len + 4 : (kind == 2) ? 5 : 4;
    @(negedge clk);
    for (int i = 0; i < MAXB; i++) req_wdata[8*i +: 8] = 8'((addr + i * 7 + 3) & 255);
    req_kind = 2'(kind);
    req_addr = 16'(addr);
    req_len = LW'(len);
    req_mot = mot[0];
    req_rbuf_size = LW'(rbuf);
    req_defer_wait = WW'(wt);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R11 busy after accept", int'(busy), 1);
    t = 0;
    final_e = -1;
    while (final_e < 0) begin
      got = 0;
      guard = 0;
      hdr_ok = 1;
      while (got < exp_len && guard < 200) begin
        tx_ready = bp ? ((guard % 3) != 1) : 1'b1;
        if (intrude && t == 0 && guard < 3) begin
          req_valid = 1'b1;
          req_addr = 16'(~addr);
          req_kind = 2'd0;
        end else begin
          req_valid = 1'b0;
        end
        if (tx_valid && tx_ready) begin
          if (int'(tx_data) != exp_hdr(kind, addr, len, mot, got)) hdr_ok = 0;
          if (tx_last != (got == exp_len - 1)) hdr_ok = 0;
          got++;
        end
        guard++;
        @(negedge clk);
      end
      tx_ready = 1'b0;
      req_valid = 1'b0;
      chk(hdr_ok && got == exp_len, "R1 R2 R3 R4 message bytes", got, exp_len);
      nb = (r_stat[t] != 0) ? 1 : (r_code[t] < 0) ? 1 : 2 + r_nd[t];
      for (int b = 0; b < nb; b++) begin
        rx_valid = 1'b1;
        rx_data = (b == 0) ? 8'(r_stat[t]) : (b == 1) ? 8'(r_code[t]) : 8'(dbyte(t, b - 2));
        rx_last = (b == nb - 1);
        @(negedge clk);
      end
      rx_valid = 1'b0;
      rx_last = 1'b0;
      v = verdict(kind, r_stat[t], r_code[t], e);
      if (v == 1 && t < 3) begin
        lows = 0;
        while (!tx_valid && lows < 5000) begin
          lows++;
          @(negedge clk);
        end
        chk(lows == wt + 1, "R8 defer gap", lows, wt + 1);
        t++;
      end else begin
        final_e = (v == 1) ? 6 : e;
      end
    end
    lim = (kind == 1) ? minv(rbuf, MAXB) : (kind == 3) ? minv(rbuf, 1) : 0;
    exp_cnt = (final_e == 0) ? minv(r_nd[t], lim) : 0;
    chk(done == 1'b1, "R11 done pulse", int'(done), 1);
    chk(int'(err_code) == final_e, "R5 R6 R7 R9 err_code", int'(err_code), final_e);
    chk(err == (final_e != 0), "R11 err flag", int'(err), int'(final_e != 0));
    chk(int'(rd_count) == exp_cnt, "R10 rd_count", int'(rd_count), exp_cnt);
    data_ok = 1;
    for (int i = 0; i < exp_cnt; i++)
      if (int'(rd_data[8*i +: 8]) != dbyte(t, i)) data_ok = 0;
    chk(data_ok, "R10 rd_data", int'(data_ok), 1);
    chk(busy == 1'b0, "R11 busy drop", int'(busy), 0);
    @(negedge clk);
    chk(done == 1'b0 && tx_valid == 1'b0, "R9 R11 nothing after done", int'(done | tx_valid), 0);
  endtask

  initial begin
    int cds[3];
    int sts[4];
    rst = 1'b1;
    repeat (5) @(negedge clk);
    // R12 reset state
    chk(busy == 1'b0 && done == 1'b0 && tx_valid == 1'b0, "R12 reset", int'(busy | done | tx_valid), 0);
    rst = 1'b0;
    @(negedge clk);

    for (int len = 1; len <= MAXB; len++) begin
      set_rep(0, 0, 8'h00, 0);
      run(0, 16'h0100 * len + 16'h21, len, 0, 0, 0, len % 2);
    end

    for (int nd = 0; nd <= MAXB + 1; nd++) begin
      for (int k = 0; k < 3; k++) begin
        int rb;
        rb = (k == 0) ? 1 : (k == 1) ? 3 : MAXB;
        set_rep(0, 0, 8'h00, nd);
        run(1, 16'hA000 + nd * 16 + k, rb, 0, rb, 0, nd % 2);
      end
    end

    // R7: I2C bits ignored on a native ACK for a native read
    set_rep(0, 0, 8'h40, 3);
    run(1, 16'h0600, 4, 0, 4, 0, 0);

    cds[0] = 8'h00; cds[1] = 8'h40; cds[2] = 8'hC0;
    for (int kind = 2; kind <= 3; kind++)
      for (int mot = 0; mot <= 1; mot++)
        for (int c = 0; c < 3; c++) begin
          set_rep(0, 0, cds[c], 2);
          run(kind, 16'h0050 + c, 1, mot, 1, 0, mot);
        end

    // R7: I2C defer then ack
    set_rep(0, 0, 8'h80, 0);
    set_rep(1, 0, 8'h00, 2);
    run(3, 16'h0051, 1, 1, 1, 3, 0);

    for (int d = 0; d <= 4; d++) begin
      for (int t = 0; t < 4; t++) set_rep(t, 0, 8'h20, 0);
      if (d < 4) set_rep(d, 0, 8'h00, 4);
      run(1, 16'h2200 + d, 4, 0, 4, d * 2 + 1, d % 2);
    end
    for (int t = 0; t < 4; t++) set_rep(t, 0, 8'h80, 0);
    run(2, 16'h0052, 1, 0, 0, 0, 1);

    sts[0] = 1; sts[1] = 2; sts[2] = 3; sts[3] = 6;
    for (int s = 0; s < 4; s++) begin
      set_rep(0, sts[s], 8'h00, 2);
      run(1, 16'h3300 + s, 2, 0, 2, 0, 0);
    end
    set_rep(0, 0, 8'h10, 0);
    run(0, 16'h4400, 2, 0, 0, 0, 0);
    set_rep(0, 0, 8'h30, 0);
    run(0, 16'h4401, 2, 0, 0, 0, 0);
    set_rep(0, 0, -1, 0);
    run(1, 16'h4402, 2, 0, 2, 0, 0);

    // R11: request while busy has no effect
    intrude = 1;
    set_rep(0, 0, 8'h00, 2);
    run(1, 16'h5A5A, 2, 0, 2, 0, 0);
    intrude = 0;
    repeat (4) @(negedge clk);
    chk(tx_valid == 1'b0 && busy == 1'b0, "R11 ignored request", int'(tx_valid | busy), 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule